// File: doc/BRIEF.md
# Oversampled Miller Pause Decoder

This block recovers the reader-to-card bit stream from a demodulated pause signal. Each clock carries one sample of the line, and a high sample marks a carrier pause. A parameter sets the sampling rate to 4 or 8 samples per bit period. While the line is idle, the decoder waits for a pause. The falling edge of the first pause fixes the phase of the bit windows for the whole frame.

Each window of samples is classified by where its single pause falls. A pause near the start is one symbol, a pause near the middle is another, and a window with no pause is a third. The symbols are mapped back to data bits using the bit decoded before them. The start of a frame, each data bit, the end of the frame with its bit length, and illegal symbol orders are reported on strobes one clock wide.

Data bits come out one bit period late. The decoder holds each bit until it knows that the bit is not the zero that begins the end-of-frame marker. That zero is therefore never delivered and never counted.

Top module: `miller_rx`

## Requirements
- R1: After reset, `sof_o`, `bit_vld_o`, `eof_o` and `err_o` are low and `len_o` is zero.
- R2: Window sample k is the k-th sample after the window starts, and 1 means pause. A window with no pause is a blank symbol. A single pause at sample 0 is a start symbol. A single pause at sample OSR/2 is a mid symbol. With OSR=4 these are 0000, 1000 and 0010; with OSR=8 they are 00000000, 10000000 and 00001000.
- R3: With OSR=8, a pause one sample late is accepted: sample 1 is a start symbol and sample 5 is a mid symbol.
- R4: While idle, the first pause sample becomes sample 0 of a window. If that window is a start symbol, `sof_o` pulses for one clock and a frame begins.
- R5: Inside a frame, a mid symbol decodes to 1. A start symbol after a 0 or right after frame start decodes to 0. A blank symbol after a 1 decodes to 0. Each bit appears on `bit_o` with a `bit_vld_o` pulse one window after the window that carried it, in frame order.
- R6: A blank symbol after a decoded 0 ends the frame. That 0 is not delivered. `eof_o` pulses and `len_o` shows the number of `bit_vld_o` pulses of that frame; `len_o` holds its value until the next end of frame.
- R7: A start symbol right after a decoded 1 pulses `err_o` and ends the frame without delivering the held bit.
- R8: A blank symbol directly after the frame start pulses `err_o` and ends the frame.
- R9: Inside a frame, a window with more than one pause, or with its pause at any other position, pulses `err_o` and ends the frame. While idle, such a window produces no output.
- R10: The bit count reaches 2325 and saturates at 2^CNT_W-1 (4095 by default).
- R11: After an end of frame or an error, the decoder hunts for a new start, and the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pause_i | input | 1 | Demodulated line sample, 1 = carrier pause |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-clock strobe qualifying `bit_o` |
| sof_o | output | 1 | One-clock strobe on frame start |
| eof_o | output | 1 | One-clock strobe on end of frame |
| len_o | output | CNT_W | Data bits in the last completed frame |
| err_o | output | 1 | One-clock strobe on an illegal symbol or order |

## Verification
The bench goes after the context cases first. A trailing zero that is encoded as a start symbol in one frame and as a blank symbol in another separates a decoder that tracks the previous bit from one that does not. A decoder that delivered the end marker's zero would produce an extra bit and a length one too large. Start symbols after a 1, a blank symbol right after the frame start, double pauses, and slipped pauses are each sent inside a frame. A decoder that skipped these checks would deliver bits instead of an error, and one without slip tolerance would raise an error on a legal frame. A junk window while idle must stay silent, and the frame after each fault must decode normally. A long frame and an over-long frame test the counter's reach and its saturation.

// File: rtl/miller_pkg.sv
package miller_pkg;
  typedef enum logic [1:0] {
    SYM_BLANK = 2'd0,
    SYM_MID   = 2'd1,
    SYM_START = 2'd2,
    SYM_BAD   = 2'd3
  } sym_t;
endpackage

// File: rtl/miller_sampler.sv
// Collects OSR line samples per window; the first window is aligned to a pause.
module miller_sampler #(
  parameter int OSR = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pause_i,
  input  logic           cont_i,
  output logic           done_o,
  output logic [OSR-1:0] win_o
);
  localparam int CW = $clog2(OSR);

  logic           run_q, run_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [OSR-2:0] smp_q, smp_d;
  logic           en;

  assign done_o = run_q && (cnt_q == CW'(OSR-1));
  assign win_o  = {pause_i, smp_q};
  assign en     = run_q || pause_i;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    smp_d = smp_q;
    if (!run_q) begin
      if (pause_i) begin
        run_d    = 1'b1;
        cnt_d    = CW'(1);
        smp_d    = '0;
        smp_d[0] = 1'b1;
      end
    end else if (done_o) begin
      run_d = cont_i;
      cnt_d = '0;
      smp_d = '0;
    end else begin
      smp_d[cnt_q] = pause_i;
      cnt_d        = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      smp_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/miller_classify.sv
// Maps one sample window to a symbol by the position of its single pause.
module miller_classify
  import miller_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic [OSR-1:0] win_i,
  output sym_t           sym_o
);
  localparam int TOL  = (OSR >= 8) ? 1 : 0;
  localparam int HALF = OSR / 2;

  int n_pause;
  int pos;

  always_comb begin
    n_pause = 0;
    pos     = 0;
    for (int k = 0; k < OSR; k++) begin
      if (win_i[k]) begin
        n_pause = n_pause + 1;
        pos     = k;
      end
    end
    if (n_pause == 0)                           sym_o = SYM_BLANK;
    else if (n_pause != 1)                      sym_o = SYM_BAD;
    else if (pos <= TOL)                        sym_o = SYM_START;
    else if (pos >= HALF && pos <= HALF + TOL)  sym_o = SYM_MID;
    else                                        sym_o = SYM_BAD;
  end
endmodule

// File: rtl/miller_seq.sv
// Symbol-to-bit mapping with previous-bit context, one-bit holdback and frame count.
module miller_seq
  import miller_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  sym_t             sym_i,
  output logic             cont_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             err_o,
  output logic [CNT_W-1:0] len_o
);
  logic             frm_q, frm_d;
  logic             hv_q, hv_d, hb_q, hb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             bit_q, bit_d, vld_d, sof_d, eof_d, err_d;
  logic             vld_q, sof_q, eof_q, err_q;
  logic             last_one, push, nb;

  assign last_one = hv_q & hb_q;
  assign cont_o   = frm_d;

  always_comb begin
    frm_d = frm_q;
    hv_d  = hv_q;
    hb_d  = hb_q;
    cnt_d = cnt_q;
    len_d = len_q;
    bit_d = bit_q;
    vld_d = 1'b0;
    sof_d = 1'b0;
    eof_d = 1'b0;
    err_d = 1'b0;
    push  = 1'b0;
    nb    = 1'b0;
    if (done_i) begin
      if (!frm_q) begin
        if (sym_i == SYM_START) begin
          sof_d = 1'b1;
          frm_d = 1'b1;
          hv_d  = 1'b0;
          cnt_d = '0;
        end
      end else begin
        unique case (sym_i)
          SYM_MID: begin
            push = 1'b1;
            nb   = 1'b1;
          end
          SYM_START: begin
            if (last_one) begin
              err_d = 1'b1;
              frm_d = 1'b0;
            end else begin
              push = 1'b1;
            end
          end
          SYM_BLANK: begin
            if (last_one) begin
              push = 1'b1;
            end else if (hv_q) begin
              eof_d = 1'b1;
              len_d = cnt_q;
              frm_d = 1'b0;
            end else begin
              err_d = 1'b1;
              frm_d = 1'b0;
            end
          end
          default: begin
            err_d = 1'b1;
            frm_d = 1'b0;
          end
        endcase
        if (push) begin
          hb_d = nb;
          hv_d = 1'b1;
          if (hv_q) begin
            vld_d = 1'b1;
            bit_d = hb_q;
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
      hv_q  <= 1'b0;
      hb_q  <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sof_q <= sof_d;
      eof_q <= eof_d;
      err_q <= err_d;
      if (done_i) begin
        frm_q <= frm_d;
        hv_q  <= hv_d;
        hb_q  <= hb_d;
        cnt_q <= cnt_d;
        len_q <= len_d;
        bit_q <= bit_d;
      end
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
  assign sof_o     = sof_q;
  assign eof_o     = eof_q;
  assign err_o     = err_q;
  assign len_o     = len_q;
endmodule

// File: rtl/miller_rx.sv
module miller_rx
  import miller_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int MAX_BITS = 2325,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pause_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic [CNT_W-1:0] len_o,
  output logic             err_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           done, cont;
  logic [OSR-1:0] win;
  sym_t           sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  miller_sampler #(.OSR(OSR)) u_smp (
    .clk(clk), .rst_n(rst_int_n), .pause_i(pause_i), .cont_i(cont),
    .done_o(done), .win_o(win)
  );

  miller_classify #(.OSR(OSR)) u_cls (
    .win_i(win), .sym_o(sym)
  );

  miller_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .done_i(done), .sym_i(sym), .cont_o(cont),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .sof_o(sof_o), .eof_o(eof_o),
    .err_o(err_o), .len_o(len_o)
  );
endmodule

// File: rtl/miller_rx_chk.sv
module miller_rx_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld_o,
  input logic             sof_o,
  input logic             eof_o,
  input logic             err_o,
  input logic [CNT_W-1:0] len_o
);
  logic             in_frm;
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frm <= 1'b0;
      seen   <= '0;
    end else begin
      if (sof_o) begin
        in_frm <= 1'b1;
        seen   <= '0;
      end else begin
        if (eof_o || err_o) in_frm <= 1'b0;
        if (bit_vld_o && seen != '1) seen <= seen + 1'b1;
      end
    end
  end

  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_vld_o, sof_o, eof_o, err_o}));
  // R5
  event_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_o | sof_o | eof_o | err_o) |=> !(bit_vld_o | sof_o | eof_o | err_o));
  // R6
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (len_o == seen));
  // R4
  sof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> !in_frm);
  // R5
  bit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> in_frm);
  // R9
  end_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_o | err_o) |-> in_frm);
endmodule

bind miller_rx miller_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld_o(bit_vld_o), .sof_o(sof_o),
  .eof_o(eof_o), .err_o(err_o), .len_o(len_o)
);

// File: tb/tb_miller_rx.sv
`timescale 1ns/1ps
module tb_miller_rx;
  localparam int CNT_W = 12;
  localparam int K_SOF = 0, K_BIT = 1, K_EOF = 2, K_ERR = 3;
  localparam int S_BLANK = 0, S_MID = 1, S_START = 2, S_BAD = 3;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } exp_t;

  logic clk, rst_n, p8, p4;
  logic b8, v8, s8, e8, r8, b4, v4, s4, e4, r4;
  logic [CNT_W-1:0] l8, l4;

  exp_t q[$];
  int   nchk, nfail, nevt, cur_osr;
  bit   finished;

  miller_rx #(.OSR(8)) dut (
    .clk(clk), .rst_n(rst_n), .pause_i(p8), .bit_o(b8), .bit_vld_o(v8),
    .sof_o(s8), .eof_o(e8), .len_o(l8), .err_o(r8)
  );
  miller_rx #(.OSR(4)) dut4 (
    .clk(clk), .rst_n(rst_n), .pause_i(p4), .bit_o(b4), .bit_vld_o(v4),
    .sof_o(s4), .eof_o(e4), .len_o(l4), .err_o(r4)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic got(input int kind, input int val);
    exp_t e;
    nevt++;
    nchk++;
    if (q.size() == 0) begin
      nfail++;
      $display("FAIL unexpected event: actual kind %0d val %0d, expected none", kind, val);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.val != val) begin
        nfail++;
        $display("FAIL %s: actual kind %0d val %0d, expected kind %0d val %0d",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  // monitor: compares every output event against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (s8) got(K_SOF, 0);
      if (v8) got(K_BIT, int'(b8));
      if (e8) got(K_EOF, int'(l8));
      if (r8) got(K_ERR, 0);
      if (s4) got(K_SOF, 0);
      if (v4) got(K_BIT, int'(b4));
      if (e4) got(K_EOF, int'(l4));
      if (r4) got(K_ERR, 0);
    end
  end

  task automatic expect_ev(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind;
    e.val  = val;
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_sym(input int s, input bit slip);
    for (int k = 0; k < cur_osr; k++) begin
      logic v;
      case (s)
        S_START: v = (k == (slip ? 1 : 0));
        S_MID:   v = (k == cur_osr / 2 + (slip ? 1 : 0));
        S_BAD:   v = (k == 0) || (k == cur_osr / 2);
        default: v = 1'b0;
      endcase
      @(negedge clk);
      if (cur_osr == 8) p8 = v; else p4 = v;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_sym(S_BLANK, 1'b0);
  endtask

  // R4 R5 R6: encode a frame from data bits, queue the expected events, drive it
  task automatic send_frame(input bit b[], input bit slip, input int exp_len);
    bit prev_one;
    expect_ev(K_SOF, 0, "R4 sof");
    foreach (b[i]) expect_ev(K_BIT, int'(b[i]), "R5 data bit");
    expect_ev(K_EOF, exp_len, "R6 eof length");
    drive_sym(S_START, 1'b0);
    prev_one = 1'b0;
    foreach (b[i]) begin
      if (b[i]) drive_sym(S_MID, slip);
      else      drive_sym(prev_one ? S_BLANK : S_START, prev_one ? 1'b0 : slip);
      prev_one = b[i];
    end
    drive_sym(prev_one ? S_BLANK : S_START, prev_one ? 1'b0 : slip);
    drive_sym(S_BLANK, 1'b0);
    idle(2);
  endtask

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    check(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit f[];
    int ev0;
    nchk = 0; nfail = 0; nevt = 0; cur_osr = 8;
    p8 = 1'b0; p4 = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({s8, v8, e8, r8, s4, v4, e4, r4} == 8'h00, "R1 strobes", 1, 0);
    check(l8 == '0 && l4 == '0, "R1 len", int'(l8), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R5 R6 8x: trailing 0 after a 1 (blank-coded end zero)
    f = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    send_frame(f, 1'b0, 7);
    drain("R6 frame 1");
    // R5 R6: first bit 0, ends with 0
    f = '{1'b0, 1'b0, 1'b1, 1'b0};
    send_frame(f, 1'b0, 4);
    // R6: empty frame
    f = new[0];
    send_frame(f, 1'b0, 0);
    // R3 slipped pauses
    f = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    send_frame(f, 1'b1, 6);
    drain("R3 slip");

    // R7 start symbol after a 1
    expect_ev(K_SOF, 0, "R4 sof");
    expect_ev(K_ERR, 0, "R7 start after one");
    drive_sym(S_START, 0); drive_sym(S_MID, 0); drive_sym(S_START, 0);
    idle(2);
    drain("R7 error");
    // R11 recovery
    f = '{1'b1, 1'b0};
    send_frame(f, 1'b0, 2);
    // R8 blank right after start
    expect_ev(K_SOF, 0, "R4 sof");
    expect_ev(K_ERR, 0, "R8 blank after start");
    drive_sym(S_START, 0); drive_sym(S_BLANK, 0);
    idle(2);
    // R9 double pause in frame
    expect_ev(K_SOF, 0, "R4 sof");
    expect_ev(K_ERR, 0, "R9 bad window in frame");
    drive_sym(S_START, 0); drive_sym(S_MID, 0); drive_sym(S_BAD, 0);
    idle(2);
    drain("R9 error");
    // R9 junk while idle is ignored
    ev0 = nevt;
    drive_sym(S_BAD, 0);
    idle(2);
    check(nevt == ev0, "R9 idle ignore", nevt - ev0, 0);
    // R11 recovery after idle junk
    f = '{1'b0, 1'b1, 1'b1};
    send_frame(f, 1'b0, 3);
    drain("R11 recovery");

    // R2 4x patterns
    cur_osr = 4;
    f = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    send_frame(f, 1'b0, 5);
    expect_ev(K_SOF, 0, "R4 sof 4x");
    expect_ev(K_ERR, 0, "R7 4x");
    drive_sym(S_START, 0); drive_sym(S_MID, 0); drive_sym(S_START, 0);
    idle(2);
    drain("R2 4x");
    cur_osr = 8;

    // R10 maximum frame length
    f = new[2325];
    foreach (f[i]) f[i] = (i % 3 == 0);
    send_frame(f, 1'b0, 2325);
    drain("R10 max frame");
    // R10 saturation
    f = new[4200];
    foreach (f[i]) f[i] = (i % 5 == 1);
    send_frame(f, 1'b0, 4095);
    drain("R10 saturation");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule